// File: doc/BRIEF.md
# Streaming Entropy Health Test Monitor

This block watches the output of a hardware entropy source and raises an alarm when the stream looks broken. It taps two streams. The first is the raw serial bit stream, one bit per cycle when a valid strobe is high. The second is the stream of 32-bit words that the generator delivers to its consumers. On the raw bits it runs three checks:

- **Ones-count check.** Ones are counted over consecutive fixed windows of 20,000 bits.
- **Long-run check.** This detects 34 identical bits in a row.
- **Noise check.** This detects 48 identical bits in a row.

On the words it runs one check: a comparator that detects a word equal to the word before it.

Every failure is reported as a single-cycle pulse on its own output. A surrounding controller can count these pulses, mask them or shut the source down. An enable input gates the whole monitor. Dropping it clears every counter and every stored history, so the checks start over when it returns.

Top module: `entropy_health_monitor`

## Requirements
- R1: After synchronous reset all four failure outputs are low.
- R2: While enabled, the monitor counts ones over each block of 20,000 accepted bits. In the cycle after the 20,000th bit, `monobit_fail` pulses high if that ones count is at most 9655 or at least 10345. A count strictly between these bounds gives no pulse.
- R3: A new window starts with the bit that follows the 20,000th bit, so consecutive windows are judged independently.
- R4: `long_run_fail` pulses for one cycle, in the cycle after the 34th consecutive identical accepted bit.
- R5: `noise_fail` pulses for one cycle, in the cycle after the 48th consecutive identical accepted bit.
- R6: A bit that differs from the previous accepted bit restarts the run length at 1. Neither run pulse repeats while one run continues; a run shorter than its length gives no pulse.
- R7: An accepted word equal to the previous accepted word pulses `stuck_fail` in the following cycle. This holds for every repetition.
- R8: The first word accepted after reset or after enable rises is never flagged.
- R9: While `enable` is low, inputs are ignored and all outputs stay low. Run, window and word history are cleared, so earlier bits never count toward a later run or window.
- R10: Cycles with the valid strobe low neither advance nor break a run or a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Monitor enable; low clears all state |
| bit_valid | input | 1 | Raw bit strobe |
| bit_in | input | 1 | Raw entropy bit |
| word_valid | input | 1 | Output word strobe |
| word_in | input | 32 | Output word |
| monobit_fail | output | 1 | Ones-count window failure pulse |
| long_run_fail | output | 1 | 34-bit identical run pulse |
| noise_fail | output | 1 | 48-bit identical run pulse |
| stuck_fail | output | 1 | Repeated output word pulse |

## Verification
The hardest case to reach from the ports is a ones count that lands exactly on a window bound. This needs 20,000 bits whose ones total is controlled to the unit.

The stimulus builds each window from an alternating prefix of chosen length, followed by a constant tail of zeros or ones. This places the total on 9655, 9656, 10344 and 10345 in turn. The windows are sent back to back, which also shows that each new window starts cleanly. The constant tails form long runs, so the run checks are exercised at the same time.

// File: rtl/ehm_pkg.sv
// Package: shared types for the entropy health monitor.
// Assumes: one failure flag per health test, bundled for the top level.
package ehm_pkg;
    typedef struct packed {
        logic mono;
        logic long_run;
        logic noise;
        logic stuck;
    } ehm_fail_t;
endpackage

// File: rtl/ehm_monobit.sv
// Module: windowed ones counter.
// Counts ones over WINDOW accepted bits. On the last bit of a window it
// judges the total against exclusive bounds and restarts at once.
// Assumes: LO < HI <= WINDOW; the enable low level clears the window.
module ehm_monobit #(
    parameter int WINDOW = 20000,
    parameter int LO     = 9655,
    parameter int HI     = 10345
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic valid_i,
    input  logic bit_i,
    output logic fail_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] ones_cnt;
    logic [CW-1:0] ones_nxt;
    logic          last_bit;

    // Ones total including the current bit, and end-of-window flag.
    always_comb begin
        ones_nxt = ones_cnt + CW'(bit_i);
        last_bit = (bit_cnt == CW'(WINDOW - 1));
    end

    // Window counters and the judged failure pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            bit_cnt  <= '0;
            ones_cnt <= '0;
            fail_o   <= 1'b0;
        end else begin
            fail_o <= 1'b0;
            if (valid_i) begin
                if (last_bit) begin
                    bit_cnt  <= '0;
                    ones_cnt <= '0;
                    fail_o   <= (ones_nxt <= CW'(LO)) || (ones_nxt >= CW'(HI));
                end else begin
                    bit_cnt  <= bit_cnt + 1'b1;
                    ones_cnt <= ones_nxt;
                end
            end
        end
    end

    assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CW'(WINDOW));
    assert_pulse_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(last_bit && valid_i && en_i));
endmodule

// File: rtl/ehm_run_detect.sv
// Module: identical-bit run detector.
// Tracks the length of the current run of equal bits, saturating at the
// longest threshold. One pulse per threshold, fired when the run reaches it.
// Assumes: SHORT_LEN < LONG_LEN; index 0 is the short threshold.
module ehm_run_detect #(
    parameter int SHORT_LEN = 34,
    parameter int LONG_LEN  = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       valid_i,
    input  logic       bit_i,
    output logic [1:0] fail_o
);
    localparam int RW = $clog2(LONG_LEN + 1);

    logic [RW-1:0] run_len;
    logic [RW-1:0] run_nxt;
    logic          prev_bit;
    logic          have_bit;
    logic          same;

    // Next run length: restart on a change, else grow up to saturation.
    always_comb begin
        same    = have_bit && (bit_i == prev_bit);
        run_nxt = !same ? RW'(1)
                : (run_len == RW'(LONG_LEN)) ? run_len : run_len + 1'b1;
    end

    // Run length and last-bit history.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_len  <= '0;
            prev_bit <= 1'b0;
            have_bit <= 1'b0;
        end else if (valid_i) begin
            run_len  <= run_nxt;
            prev_bit <= bit_i;
            have_bit <= 1'b1;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_thr
        localparam int THR = (g == 0) ? SHORT_LEN : LONG_LEN;
        // Pulse once when the run first reaches this threshold.
        always_ff @(posedge clk) begin
            if (!rst_n || !en_i)
                fail_o[g] <= 1'b0;
            else
                fail_o[g] <= valid_i && (run_nxt == RW'(THR)) && (run_len != RW'(THR));
        end
        assert_run_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
            fail_o[g] |=> !fail_o[g]);
    end

    assert_run_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RW'(LONG_LEN));
endmodule

// File: rtl/ehm_stuck_word.sv
// Module: repeated output word comparator.
// Flags an accepted word equal to the previous accepted word.
// Assumes: the first word after reset or enable has nothing to compare with.
module ehm_stuck_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              fail_o
);
    logic [WORD_W-1:0] prev_word;
    logic              have_prev;

    // Stored previous word and the comparison pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            prev_word <= '0;
            have_prev <= 1'b0;
            fail_o    <= 1'b0;
        end else begin
            fail_o <= valid_i && have_prev && (word_i == prev_word);
            if (valid_i) begin
                prev_word <= word_i;
                have_prev <= 1'b1;
            end
        end
    end

    assert_first_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> $past(have_prev));
endmodule

// File: rtl/entropy_health_monitor.sv
// Module: top of the entropy health monitor.
// Runs a windowed ones count, two run-length checks and a repeated-word
// check in parallel and presents each failure as a one-cycle pulse.
// Assumes: inputs synchronous to clk; enable low clears all test state.
module entropy_health_monitor
    import ehm_pkg::*;
#(
    parameter int WINDOW    = 20000,
    parameter int MONO_LO   = 9655,
    parameter int MONO_HI   = 10345,
    parameter int LONG_LEN  = 34,
    parameter int NOISE_LEN = 48,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              monobit_fail,
    output logic              long_run_fail,
    output logic              noise_fail,
    output logic              stuck_fail
);
    ehm_fail_t  fails;
    logic [1:0] run_fail;

    ehm_monobit #(.WINDOW(WINDOW), .LO(MONO_LO), .HI(MONO_HI)) u_mono (
        .clk(clk), .rst_n(rst_n), .en_i(enable),
        .valid_i(bit_valid), .bit_i(bit_in), .fail_o(fails.mono));

    ehm_run_detect #(.SHORT_LEN(LONG_LEN), .LONG_LEN(NOISE_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .en_i(enable),
        .valid_i(bit_valid), .bit_i(bit_in), .fail_o(run_fail));

    ehm_stuck_word #(.WORD_W(WORD_W)) u_stuck (
        .clk(clk), .rst_n(rst_n), .en_i(enable),
        .valid_i(word_valid), .word_i(word_in), .fail_o(fails.stuck));

    // Bundle the run pulses and drive the ports.
    always_comb begin
        fails.long_run = run_fail[0];
        fails.noise    = run_fail[1];
        monobit_fail   = fails.mono;
        long_run_fail  = fails.long_run;
        noise_fail     = fails.noise;
        stuck_fail     = fails.stuck;
    end

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !(monobit_fail || long_run_fail || noise_fail || stuck_fail));
    assert_noise_needs_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (long_run_fail || noise_fail || monobit_fail) |-> $past(bit_valid));
endmodule

// File: tb/entropy_health_monitor_tb.sv
module entropy_health_monitor_tb;
    localparam int WIN = 20000;
    localparam int LO  = 9655;
    localparam int HI  = 10345;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic        monobit_fail, long_run_fail, noise_fail, stuck_fail;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    // Reference model state
    int  m_bits = 0, m_ones = 0, m_run = 0;
    bit  m_have = 0, m_last = 0, m_havew = 0;
    logic [31:0] m_prevw = '0;

    always #5 clk = ~clk;

    entropy_health_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .word_valid(word_valid), .word_in(word_in),
        .monobit_fail(monobit_fail), .long_run_fail(long_run_fail),
        .noise_fail(noise_fail), .stuck_fail(stuck_fail));

    // One cycle of stimulus; the expected flags are pushed after the edge.
    task automatic cyc(input bit en, input bit bv, input bit b,
                       input bit wv, input logic [31:0] w);
        logic [3:0] e;
        @(negedge clk);
        enable = en; bit_valid = bv; bit_in = b; word_valid = wv; word_in = w;
        @(posedge clk);
        e = '0;
        if (!en) begin
            m_bits = 0; m_ones = 0; m_run = 0; m_have = 0; m_havew = 0;
        end else begin
            if (bv) begin
                m_run  = (m_have && b == m_last) ? m_run + 1 : 1;
                m_have = 1; m_last = b;
                e[2] = (m_run == 34);
                e[1] = (m_run == 48);
                m_ones += b; m_bits++;
                if (m_bits == WIN) begin
                    e[3] = (m_ones <= LO) || (m_ones >= HI);
                    m_bits = 0; m_ones = 0;
                end
            end
            if (wv) begin
                e[0] = m_havew && (w == m_prevw);
                m_prevw = w; m_havew = 1;
            end
        end
        q.push_back('{e, cur_req});
    endtask

    task automatic send_bit(input bit b);
        cyc(1, 1, b, 0, '0);
    endtask

    task automatic send_word(input logic [31:0] w);
        cyc(1, 0, 0, 1, w);
    endtask

    // Window: alternating prefix (starting with 1) then constant tail.
    task automatic send_window(input int alt_len, input bit tail);
        for (int i = 0; i < WIN; i++)
            send_bit(i < alt_len ? ((i % 2) == 0) : tail);
    endtask

    // Monitor: compare outputs against the queued expectation.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it  = q.pop_front();
            act = {monobit_fail, long_run_fail, noise_fail, stuck_fail};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: {mono,long,noise,stuck} actual %b expected %b at %0t",
                         it.tag, act, it.exp, $time);
            end
        end
    end

    initial begin
        #(10 * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low while and after reset
        checks++;
        if ({monobit_fail, long_run_fail, noise_fail, stuck_fail} !== 4'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 0000",
                     {monobit_fail, long_run_fail, noise_fail, stuck_fail});
        end
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (2) cyc(0, 0, 0, 0, '0);

        // R4 R5: run of 50 ones with idle gaps (R10)
        cur_req = "R4_R5_R10";
        for (int i = 0; i < 50; i++) begin
            send_bit(1);
            if (i % 7 == 3) cyc(1, 0, 0, 0, '0);
        end
        // R6: break, 33 zeros, change
        cur_req = "R6";
        for (int i = 0; i < 33; i++) send_bit(0);
        send_bit(1);
        for (int i = 0; i < 34; i++) send_bit(0);
        send_bit(1);

        // R7 R8: words
        cur_req = "R7_R8";
        send_word(32'hA5A5_0001);
        send_word(32'h1234_5678);
        send_word(32'h1234_5678);
        send_word(32'h1234_5678);
        send_word(32'hFFFF_0000);
        cyc(1, 1, 1, 1, 32'hFFFF_0000);

        // R9: disable clears history and ignores inputs
        cur_req = "R9";
        for (int i = 0; i < 33; i++) send_bit(1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, 32'hFFFF_0000);
        send_bit(1);
        send_word(32'hFFFF_0000);
        for (int i = 0; i < 40; i++) send_bit(1);

        // R2 R3: back-to-back windows at the bounds (fresh window after disable)
        cur_req = "R2_R3";
        cyc(0, 0, 0, 0, '0);
        send_window(19310, 0);   // 9655 ones: fail
        send_window(WIN, 0);     // 10000 ones: pass
        send_window(19312, 0);   // 9656 ones: pass
        send_window(19310, 1);   // 10345 ones: fail
        send_window(19312, 1);   // 10344 ones: pass
        repeat (3) cyc(1, 0, 0, 0, '0);

        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule